// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

A 16-bit down counter driven by a programmable power-of-two clock divider. It has a two-register bus map: a running-count register and a control register. Writing the running-count register loads the counter and a hidden period register in one operation. The control register sets the divide ratio and chooses between one-shot and periodic (auto-reload) operation. It also starts or holds counting and can power the timer down.

Power-down can come from the local control bit or from an external power-control input. While the timer is powered down, the counter, period and divider keep their values. The running-count register then reads as zero and ignores writes. The control register stays accessible so that software can power the timer back up. The block raises a one-cycle pulse when a decrement brings the counter to zero; an interrupt controller can use this pulse.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, the counter, the period register, the divider and all control fields are zero, and `zero_pulse_o` is low.
- R2: Address 1 is the control register. Bit 6 is power-down, bit 5 is reload, bit 4 is run, and bits 3:0 are the prescale code. Bits 15:7 read as zero. The register can be written and read even while the timer is powered down, and any write to it clears the divider.
- R3: A write to address 0 while the timer is powered up loads `wdata_i` into both the counter and the period register and clears the divider.
- R4: A read (`sel_i`=1, `wr_i`=0) of address 0 returns the counter while the timer is powered up. It returns zero while control bit 6 or `ext_pd_i` is set, and a write to address 0 in that state changes nothing. `rdata_o` is combinational and is zero when no read is selected.
- R5: While the timer is powered up and run is 1, the counter decrements by one every 2^(code+1) clock cycles. The first decrement falls 2^(code+1) cycles after the load or control write that cleared the divider.
- R6: With run at 0, the counter and the divider hold their values.
- R7: While the timer is powered down by either source, the counter, period and divider hold. Counting resumes from the same divider phase when the timer is powered up again.
- R8: With reload at 0, a counter at zero stays at zero on later ticks.
- R9: With reload at 1, the first tick after the counter shows zero loads the period value, and decrementing continues from there.
- R10: `zero_pulse_o` is high for exactly the one cycle in which a decrement has just made the counter zero. A load or reload of zero does not raise it.
- R11: If a count write and a divider tick fall in the same cycle, the write wins and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = running count, 1 = control |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| ext_pd_i | input | 1 | External power-down request |
| zero_pulse_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Several rules are checked by assertions on every cycle: the counter holds while the timer is powered down or not running, and blocked writes leave the counter untouched. Every decrement is exactly one and every reload restores the period. A counter at zero stays there without reload, the pulse coincides with a zero count, and the divider never passes its limit. The exact decrement period for each prescale code, the divider phase kept across power-down, and the collision between a write and a tick are different: only the bench's cycle-accurate reference model can show them. That model is compared against every read and against every cycle of `zero_pulse_o`, under both random and directed traffic.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PS_W  = 4;
  localparam int unsigned BUS_W = 16;

  typedef struct packed {
    logic           pwr_dn;
    logic           reload;
    logic           run;
    logic [PS_W-1:0] pscale;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic ADDR_CNT = 1'b0;
  localparam logic ADDR_CTL = 1'b1;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned PS_W = 4,
  localparam int unsigned NSEL = 2 ** PS_W,
  localparam int unsigned DIV_W = NSEL
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] limit_tbl [NSEL];
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // limit for code g is 2^(g+1)-1: the low g+1 bits set
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign limit_tbl[g] = {{(DIV_W-1-g){1'b0}}, {(g+1){1'b1}}};
  end

  assign limit  = limit_tbl[sel_i];
  assign tick_o = en_i && (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (en_i)   div_q <= tick_o ? '0 : div_q + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= limit); // R5
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(div_q)); // R6
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             cnt_is_zero;

  assign cnt_is_zero = (cnt_q == '0);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      zero_o <= 1'b0;
    end else begin
      zero_o <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
        per_q <= load_val_i;
      end else if (tick_i) begin
        if (!cnt_is_zero) begin
          cnt_q  <= cnt_q - 1'b1;
          zero_o <= (cnt_q == CNT_W'(1));
        end else if (reload_i) begin
          cnt_q <= per_q;
        end
      end
    end
  end

  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !cnt_is_zero) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_STOP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_is_zero && !reload_i) |=> cnt_q == '0); // R8
  AST_RELOAD_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_is_zero && reload_i) |=> cnt_q == $past(per_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q) && $stable(per_q)); // R6
  AST_PULSE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> cnt_is_zero); // R10
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             ext_pd_i,
  output logic             zero_pulse_o
);
  tmr_ctrl_t        ctrl_q;
  logic             powered, run_en;
  logic             wr_cnt, wr_ctl, rd_sel;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  assign powered = !ctrl_q.pwr_dn && !ext_pd_i;
  assign run_en  = powered && ctrl_q.run;
  assign rd_sel  = sel_i && !wr_i;
  assign wr_ctl  = sel_i && wr_i && (addr_i == ADDR_CTL);
  assign wr_cnt  = sel_i && wr_i && (addr_i == ADDR_CNT) && powered;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctl)  ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  timer_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_en),
    .clr_i  (wr_cnt || wr_ctl),
    .sel_i  (ctrl_q.pscale),
    .tick_o (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .tick_i     (tick),
    .reload_i   (ctrl_q.reload),
    .cnt_o      (cnt),
    .zero_o     (zero_pulse_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_sel) begin
      if (addr_i == ADDR_CTL) rdata_o = BUS_W'(ctrl_q);
      else if (powered)       rdata_o = BUS_W'(cnt);
    end
  end

  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == ADDR_CNT && !powered) |=> $stable(cnt)); // R4
  AST_PD_RETAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !powered |=> $stable(cnt)); // R7
  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (powered && ctrl_q.run)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_pulse_o |=> !zero_pulse_o); // R10
endmodule

// File: tb/tb_prescaled_down_timer.sv
module tb_prescaled_down_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, wr_i = 1'b0, addr_i = 1'b0, ext_pd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        zero_pulse_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prescaled_down_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_pd_i(ext_pd_i),
    .zero_pulse_o(zero_pulse_o)
  );

  // reference model
  logic [15:0] m_cnt, m_per, m_div;
  logic [6:0]  m_ctl;
  logic        m_pulse;

  function automatic logic [15:0] lim_of(input logic [3:0] p);
    return 16'((32'd1 << (p + 1)) - 1);
  endfunction

  function automatic logic m_powered();
    return !m_ctl[6] && !ext_pd_i;
  endfunction

  function automatic logic [15:0] m_rdata();
    if (!(sel_i && !wr_i)) return 16'h0;
    if (addr_i) return {9'h0, m_ctl};
    return m_powered() ? m_cnt : 16'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = '0; m_per = '0; m_div = '0; m_ctl = '0; m_pulse = 1'b0;
    end else begin
      logic pw, run, tk, wc, wt;
      pw  = m_powered();
      run = pw && m_ctl[4];
      tk  = run && (m_div == lim_of(m_ctl[3:0]));
      wc  = sel_i && wr_i && !addr_i && pw;
      wt  = sel_i && wr_i && addr_i;
      m_pulse = 1'b0;
      if (wc) begin
        m_cnt = wdata_i; m_per = wdata_i;
      end else if (tk) begin
        if (m_cnt != 0) begin
          m_cnt = m_cnt - 1; m_pulse = (m_cnt == 0);
        end else if (m_ctl[5]) m_cnt = m_per;
      end
      if (wc || wt) m_div = '0;
      else if (run) m_div = tk ? 16'h0 : m_div + 1;
      if (wt) m_ctl = wdata_i[6:0];
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // R10: pulse compared every cycle, away from the edge
  always @(negedge clk_i) if (rst_ni && !done) chk("R10", {15'h0, zero_pulse_o}, {15'h0, m_pulse});

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); sel_i = 0; wr_i = 0;
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk_i); sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
  endtask

  task automatic rd(input string req, input logic a);
    @(negedge clk_i); sel_i = 1; wr_i = 0; addr_i = a;
    #1 chk(req, rdata_o, m_rdata());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd("R1", 1'b0); chk("R1", rdata_o, 16'h0);
    rd("R1", 1'b1); chk("R1", rdata_o, 16'h0);
    // R2 reserved bits read zero
    wr(1'b1, 16'hFFC5); rd("R2", 1'b1); chk("R2", rdata_o, 16'h0045);
    // R4 powered down: read zero, write ignored
    wr(1'b0, 16'h1234); rd("R4", 1'b0); chk("R4", rdata_o, 16'h0);
    wr(1'b1, 16'h0000); rd("R4", 1'b0); chk("R4", rdata_o, 16'h0);
    // R3 load
    wr(1'b0, 16'h0005); rd("R3", 1'b0); chk("R3", rdata_o, 16'h0005);
    // R5 code 1 -> /4: first decrement 4 cycles after control write
    wr(1'b1, 16'h0011); idle(3); rd("R5", 1'b0); chk("R5", rdata_o, 16'h0005);
    idle(1); rd("R5", 1'b0); chk("R5", rdata_o, 16'h0004);
    // R6 hold
    wr(1'b1, 16'h0001); idle(20); rd("R6", 1'b0); chk("R6", rdata_o, 16'h0004);
    // R7 external power-down retains value
    wr(1'b1, 16'h0010); idle(1); ext_pd_i = 1; idle(30); rd("R7", 1'b0);
    ext_pd_i = 0; rd("R7", 1'b0);
    // R8 one-shot stops at zero
    wr(1'b0, 16'h0002); idle(40); rd("R8", 1'b0); chk("R8", rdata_o, 16'h0000);
    // R9 reload
    wr(1'b1, 16'h0030); wr(1'b0, 16'h0003); idle(7); rd("R9", 1'b0); chk("R9", rdata_o, 16'h0000);
    idle(1); rd("R9", 1'b0); chk("R9", rdata_o, 16'h0003);
    // R11 write on tick edge: load at edge L, tick due at L+2
    wr(1'b0, 16'h0009); idle(1); wr(1'b0, 16'h0007); rd("R11", 1'b0); chk("R11", rdata_o, 16'h0007);
    // R5 code 15 -> /65536
    wr(1'b1, 16'h001F); wr(1'b0, 16'h0003); idle(65534); rd("R5", 1'b0); chk("R5", rdata_o, 16'h0003);
    idle(1); rd("R5", 1'b0); chk("R5", rdata_o, 16'h0002);
    // random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(1'b1, {9'h0, ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom_range(0, 3) != 0),
                     4'($urandom_range(0, 3))});
        1: wr(1'b0, 16'($urandom_range(0, 12)));
        2, 3: rd("R4", 1'b0);
        4: rd("R2", 1'b1);
        5: begin @(negedge clk_i); sel_i = 0; ext_pd_i = ($urandom_range(0, 5) == 0); end
        default: idle($urandom_range(1, 6));
      endcase
    end
    idle(2);
    finish_run();
  end
endmodule